// File: doc/BRIEF.md
# Sensor Front-End Command Decoder

This block holds the control state of an eight-channel bridge-sensor front end and drives its analog control lines. A two-wire serial target placed in front of it strips the bus framing and hands over three kinds of event: a register pointer, a parameter byte written by the host, and a request for the next read byte. The decoder answers each pointer with the number of parameter bytes that register takes. It executes commands that take no parameters at once, and it commits register writes as their bytes arrive.

Outputs cover the input-mux channel, the amplifier gain code and the signed offset word of the active channel. They also cover the regulator voltage and enable, the output-mux choice between amplifier and regulator-current signal, and analog power-down. Sleep keeps every register but blocks all commands except wake and the regulator settings.

A small transfer state machine tracks the byte position inside a transaction. Its states are `ST_IDLE` (no pointer since reset), `ST_BYTE0` (next byte is the first parameter), `ST_BYTE1` (next byte is the second) and `ST_DONE` (further bytes are ignored and read as zero). A pointer moves to `ST_BYTE0`, or to `ST_DONE` when the register takes no bytes. A byte moves `ST_BYTE0` to `ST_BYTE1` for two-byte registers and to `ST_DONE` otherwise. A byte moves `ST_BYTE1` to `ST_DONE`.

Top module: `sfe_cmd_decoder`

## Requirements
- R1: After reset: mux_sel=0 (channel 1), gain_code=0, ldo_low_v=0 (3 V), ldo_en=1, offset_word=0, isense_sel=0, analog_pd=0, param_count=0.
- R2: Pointers 0x10,0x12,0x14,0x15,0x18,0x1A,0x1C,0x1E select channels 1..8; mux_sel shows 0..7 from the clock edge that takes the pointer.
- R3: Register 0x06 takes one byte; bits [2:0] become gain_code (0..7 = gains 2,20,40,80,150,300,600,760).
- R4: Register 0x07 takes one byte; bit 0 drives ldo_low_v (1 = 2.65 V); bit 1 set turns the regulator off in sleep only; ldo_en = !analog_pd | !bit1.
- R5: Offset registers 0x20,0x22,0x24,0x25,0x28,0x2A,0x2C,0x2E (channels 1..8) take two bytes: byte 1 bits [2:0] are word bits [10:8] (bit 10 = negative sign), byte 2 is bits [7:0]; the word is committed only on byte 2.
- R6: offset_word is the stored word of the active channel only.
- R7: Pointer 0x08 sets isense_sel; any channel-select pointer clears it.
- R8: Pointer 0x05 sets analog_pd; pointer 0x04 clears it.
- R9: While asleep only 0x04 and writes to 0x07 take effect; all other commands and writes are ignored, and register reads still work.
- R10: Pointer 0x01 (while awake) restores every register, including all offset words, to its reset value.
- R11: Reads return, byte by byte: 0x02 gives 0x89 then 0x10; 0x03 gives 0x00 then 0x01; 0x06 gives {00000,gain}; 0x07 gives {000000,ldo bits}; offset registers give {00000,word[10:8]} then word[7:0]; anything else gives 0x00.
- R12: param_count is 2 for 0x02, 0x03 and offset registers, 1 for 0x06 and 0x07, and 0 for every other pointer.
- R13: Bytes beyond a register's count, and bytes to unlisted or read-only pointers, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_stb | input | 1 | A register pointer is presented this cycle |
| ptr_addr | input | 8 | Register pointer |
| wr_stb | input | 1 | A written parameter byte is presented this cycle |
| wr_byte | input | 8 | Written parameter byte |
| rd_stb | input | 1 | The current read byte was consumed; advance |
| rd_byte | output | 8 | Read byte at the current position |
| param_count | output | 2 | Parameter byte count of the current pointer |
| mux_sel | output | 3 | Active input channel, 0 = channel 1 |
| gain_code | output | 3 | Amplifier gain code |
| offset_word | output | 11 | Sign and magnitude of the active channel's offset |
| ldo_low_v | output | 1 | Regulator at 2.65 V when 1, 3 V when 0 |
| ldo_en | output | 1 | Regulator enable |
| isense_sel | output | 1 | Output mux shows regulator current when 1 |
| analog_pd | output | 1 | Analog power-down (sleep) |

## Verification
A wrong transfer state shows up on the next byte. A two-byte offset write lands in the wrong bits or is never committed, and a read returns bytes in the wrong order. Both are visible on offset_word or rd_byte within one cycle of the byte. A stuck sleep or current-sense flag shows at once on analog_pd, ldo_en or isense_sel. It also shows in the next blocked or accepted command, which the directed scenarios issue both awake and asleep. A wrong offset bank entry appears on offset_word as soon as that channel is selected, and the bench selects each written channel.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYTE0,
        ST_BYTE1,
        ST_DONE
    } xfer_state_t;

    typedef enum logic [3:0] {
        K_NONE,
        K_NOP,
        K_RESET,
        K_ID,
        K_VER,
        K_WAKE,
        K_SLEEP,
        K_GAIN,
        K_LDO,
        K_ISENSE,
        K_CHSEL,
        K_OFFSET
    } cmd_kind_t;

    // Low nibble to channel slot: {valid, index}
    function automatic logic [3:0] slot_of(input logic [3:0] lo);
        case (lo)
            4'h0:    slot_of = 4'b1_000;
            4'h2:    slot_of = 4'b1_001;
            4'h4:    slot_of = 4'b1_010;
            4'h5:    slot_of = 4'b1_011;
            4'h8:    slot_of = 4'b1_100;
            4'hA:    slot_of = 4'b1_101;
            4'hC:    slot_of = 4'b1_110;
            4'hE:    slot_of = 4'b1_111;
            default: slot_of = 4'b0_000;
        endcase
    endfunction

endpackage

// File: rtl/sfe_addr_dec.sv
module sfe_addr_dec
    import sfe_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic [7:0]      addr,
    output cmd_kind_t       kind,
    output logic [CH_W-1:0] slot,
    output logic [1:0]      nbytes
);
    logic [3:0] s;

    always_comb begin
        s    = slot_of(addr[3:0]);
        slot = CH_W'(s[2:0]);
        kind = K_NONE;
        if (addr[7:4] == 4'h1 && s[3])      kind = K_CHSEL;
        else if (addr[7:4] == 4'h2 && s[3]) kind = K_OFFSET;
        else begin
            case (addr)
                8'h00:   kind = K_NOP;
                8'h01:   kind = K_RESET;
                8'h02:   kind = K_ID;
                8'h03:   kind = K_VER;
                8'h04:   kind = K_WAKE;
                8'h05:   kind = K_SLEEP;
                8'h06:   kind = K_GAIN;
                8'h07:   kind = K_LDO;
                8'h08:   kind = K_ISENSE;
                default: kind = K_NONE;
            endcase
        end
        case (kind)
            K_ID, K_VER, K_OFFSET: nbytes = 2'd2;
            K_GAIN, K_LDO:         nbytes = 2'd1;
            default:               nbytes = 2'd0;
        endcase
    end
endmodule

// File: rtl/sfe_offset_bank.sv
module sfe_offset_bank #(
    parameter int NCH  = 8,
    parameter int W    = 11,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [W-1:0]    wr_word,
    input  logic [CH_W-1:0] act_ch,
    input  logic [CH_W-1:0] rb_ch,
    output logic [W-1:0]    act_word,
    output logic [W-1:0]    rb_word
);
    logic [W-1:0] words [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [CH_W-1:0] IDX = CH_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        words[g] <= '0;
            else if (clr)                      words[g] <= '0;
            else if (wr_en && wr_ch == IDX)    words[g] <= wr_word;
        end

        AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(clr || (wr_en && wr_ch == IDX)) |=> $stable(words[g])); // R5
    end

    assign act_word = words[act_ch];
    assign rb_word  = words[rb_ch];
endmodule

// File: rtl/sfe_cmd_decoder.sv
module sfe_cmd_decoder
    import sfe_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int OFS_W  = 11,
    parameter int GAIN_W = 3,
    localparam int CH_W  = $clog2(NCH),
    localparam int HI_W  = OFS_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_stb,
    input  logic [7:0]        ptr_addr,
    input  logic              wr_stb,
    input  logic [7:0]        wr_byte,
    input  logic              rd_stb,
    output logic [7:0]        rd_byte,
    output logic [1:0]        param_count,
    output logic [CH_W-1:0]   mux_sel,
    output logic [GAIN_W-1:0] gain_code,
    output logic [OFS_W-1:0]  offset_word,
    output logic              ldo_low_v,
    output logic              ldo_en,
    output logic              isense_sel,
    output logic              analog_pd
);
    xfer_state_t state_q, state_d;
    logic [7:0]        cur_ptr_q;
    logic [CH_W-1:0]   ch_q;
    logic [GAIN_W-1:0] gain_q;
    logic [1:0]        ldo_q;
    logic              isense_q, sleep_q;
    logic [HI_W-1:0]   hi_q;

    cmd_kind_t       in_kind, cur_kind;
    logic [CH_W-1:0] in_slot, cur_slot;
    logic [1:0]      in_nb, cur_nb;
    logic            awake, step, soft_rst, ofs_wr;
    logic [OFS_W-1:0] rb_word;

    sfe_addr_dec #(.CH_W(CH_W)) u_dec_in (
        .addr(ptr_addr), .kind(in_kind), .slot(in_slot), .nbytes(in_nb));
    sfe_addr_dec #(.CH_W(CH_W)) u_dec_cur (
        .addr(cur_ptr_q), .kind(cur_kind), .slot(cur_slot), .nbytes(cur_nb));

    assign awake    = !sleep_q;
    assign step     = !ptr_stb && (wr_stb || rd_stb);
    assign soft_rst = ptr_stb && in_kind == K_RESET && awake;
    assign ofs_wr   = !ptr_stb && wr_stb && state_q == ST_BYTE1
                      && cur_kind == K_OFFSET && awake;

    sfe_offset_bank #(.NCH(NCH), .W(OFS_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .wr_en(ofs_wr), .wr_ch(cur_slot), .wr_word({hi_q, wr_byte}),
        .act_ch(ch_q), .rb_ch(cur_slot),
        .act_word(offset_word), .rb_word(rb_word));

    // Transfer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_ptr_q <= 8'h00;
        end else begin
            state_q <= state_d;
            if (ptr_stb) cur_ptr_q <= ptr_addr;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ptr_stb) begin
            state_d = (in_nb == 2'd0) ? ST_DONE : ST_BYTE0;
        end else if (step) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BYTE0: state_d = (cur_nb == 2'd2) ? ST_BYTE1 : ST_DONE;
                ST_BYTE1: state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
            endcase
        end
    end

    // Control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0; gain_q <= '0; ldo_q <= '0;
            isense_q <= 1'b0; sleep_q <= 1'b0; hi_q <= '0;
        end else if (ptr_stb) begin
            if (in_kind == K_WAKE) sleep_q <= 1'b0;
            else if (awake) begin
                unique case (in_kind)
                    K_RESET: begin
                        ch_q <= '0; gain_q <= '0; ldo_q <= '0;
                        isense_q <= 1'b0; hi_q <= '0;
                    end
                    K_SLEEP:  sleep_q  <= 1'b1;
                    K_ISENSE: isense_q <= 1'b1;
                    K_CHSEL: begin
                        ch_q     <= in_slot;
                        isense_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end else if (wr_stb && state_q == ST_BYTE0) begin
            if (cur_kind == K_LDO)                  ldo_q  <= wr_byte[1:0];
            else if (cur_kind == K_GAIN && awake)   gain_q <= wr_byte[GAIN_W-1:0];
            else if (cur_kind == K_OFFSET && awake) hi_q   <= wr_byte[HI_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        rd_byte = 8'h00;
        if (state_q == ST_BYTE0 || state_q == ST_BYTE1) begin
            unique case (cur_kind)
                K_ID:     rd_byte = (state_q == ST_BYTE1) ? 8'h10 : 8'h89;
                K_VER:    rd_byte = (state_q == ST_BYTE1) ? 8'h01 : 8'h00;
                K_GAIN:   rd_byte = 8'(gain_q);
                K_LDO:    rd_byte = {6'b0, ldo_q};
                K_OFFSET: rd_byte = (state_q == ST_BYTE1) ? rb_word[7:0]
                                                          : 8'(rb_word[OFS_W-1:8]);
                default:  rd_byte = 8'h00;
            endcase
        end
        param_count = cur_nb;
        mux_sel     = ch_q;
        gain_code   = gain_q;
        ldo_low_v   = ldo_q[0];
        ldo_en      = !sleep_q || !ldo_q[1];
        isense_sel  = isense_q;
        analog_pd   = sleep_q;
    end

    AST_ACTIVE_LDO_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !analog_pd |-> ldo_en); // R4
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (analog_pd && $past(analog_pd)) |-> ($stable(gain_code) && $stable(mux_sel))); // R9
    AST_ISENSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_stb && !analog_pd && ptr_addr[7:4] == 4'h1 && slot_of(ptr_addr[3:0]) != 4'h0)
        |=> !isense_sel); // R7
    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_stb && ptr_addr == 8'h04) |=> !analog_pd); // R8
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        param_count != 2'd3); // R12
endmodule

// File: tb/tb_sfe_cmd_decoder.sv
module tb_sfe_cmd_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_stb = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] ptr_addr = 8'h00, wr_byte = 8'h00;
    logic [7:0] rd_byte;
    logic [1:0] param_count;
    logic [2:0] mux_sel, gain_code;
    logic [10:0] offset_word;
    logic ldo_low_v, ldo_en, isense_sel, analog_pd;
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    sfe_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .ptr_stb(ptr_stb), .ptr_addr(ptr_addr),
        .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte),
        .param_count(param_count), .mux_sel(mux_sel), .gain_code(gain_code),
        .offset_word(offset_word), .ldo_low_v(ldo_low_v), .ldo_en(ldo_en),
        .isense_sel(isense_sel), .analog_pd(analog_pd));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_ptr(input logic [7:0] a);
        ptr_addr = a; ptr_stb = 1'b1;
        @(negedge clk); ptr_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        wr_byte = b; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] v);
        v = rd_byte; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mux", mux_sel, 0);       check("R1 gain", gain_code, 0);
        check("R1 ldov", ldo_low_v, 0);    check("R1 ldoen", ldo_en, 1);
        check("R1 ofs", offset_word, 0);   check("R1 isense", isense_sel, 0);
        check("R1 pd", analog_pd, 0);      check("R1 cnt", param_count, 0);
    endtask

    task automatic t_chsel();
        logic [7:0] adr [8] = '{8'h10, 8'h12, 8'h14, 8'h15, 8'h18, 8'h1A, 8'h1C, 8'h1E};
        for (int i = 0; i < 8; i++) begin
            send_ptr(adr[i]);
            check("R2 chsel", mux_sel, i);
            check("R12 chsel cnt", param_count, 0);
        end
    endtask

    task automatic t_gain();
        logic [7:0] v;
        send_ptr(8'h06);
        check("R12 gain cnt", param_count, 1);
        send_byte(8'h04);
        check("R3 gain", gain_code, 4);
        send_byte(8'h07);
        check("R13 extra byte", gain_code, 4);
        send_ptr(8'h06); read_byte(v);
        check("R11 gain rd", v, 8'h04);
    endtask

    task automatic t_offset();
        logic [7:0] v;
        send_ptr(8'h25);
        check("R12 ofs cnt", param_count, 2);
        send_byte(8'h04); send_byte(8'h89);
        send_ptr(8'h15);
        check("R6 ch4 ofs", offset_word, 11'h489);
        send_ptr(8'h10);
        check("R6 ch1 ofs", offset_word, 0);
        send_ptr(8'h15);
        send_ptr(8'h25); send_byte(8'h00);
        check("R5 no commit on byte1", offset_word, 11'h489);
        send_byte(8'h10);
        check("R5 commit", offset_word, 11'h010);
        send_ptr(8'h25); read_byte(v);
        check("R11 ofs rd0", v, 8'h00);
        read_byte(v);
        check("R11 ofs rd1", v, 8'h10);
        send_ptr(8'h2E); send_byte(8'h03); send_byte(8'hFF);
        send_ptr(8'h1E);
        check("R6 ch8 ofs", offset_word, 11'h3FF);
    endtask

    task automatic t_ids();
        logic [7:0] v;
        send_ptr(8'h02);
        check("R12 id cnt", param_count, 2);
        read_byte(v); check("R11 id0", v, 8'h89);
        read_byte(v); check("R11 id1", v, 8'h10);
        read_byte(v); check("R11 id past end", v, 8'h00);
        send_ptr(8'h03);
        read_byte(v); check("R11 ver0", v, 8'h00);
        read_byte(v); check("R11 ver1", v, 8'h01);
        send_ptr(8'h30);
        check("R12 unlisted cnt", param_count, 0);
        read_byte(v); check("R11 unlisted rd", v, 8'h00);
        send_ptr(8'h09); send_byte(8'h07);
        check("R13 unlisted wr gain", gain_code, 4);
        check("R13 unlisted wr mux", mux_sel, 7);
        send_ptr(8'h02); send_byte(8'h00);
        check("R13 read-only wr", offset_word, 11'h3FF);
    endtask

    task automatic t_isense();
        send_ptr(8'h08);
        check("R7 isense set", isense_sel, 1);
        check("R12 isense cnt", param_count, 0);
        send_ptr(8'h06); send_byte(8'h04);
        check("R7 isense kept", isense_sel, 1);
        send_ptr(8'h12);
        check("R7 isense cleared", isense_sel, 0);
        check("R2 ch2", mux_sel, 1);
    endtask

    task automatic t_sleep();
        logic [7:0] v;
        send_ptr(8'h07); send_byte(8'h02);
        check("R4 ldo on awake", ldo_en, 1);
        check("R4 ldov 3V", ldo_low_v, 0);
        send_ptr(8'h05);
        check("R8 sleep", analog_pd, 1);
        check("R4 ldo off in sleep", ldo_en, 0);
        send_ptr(8'h06); send_byte(8'h07);
        check("R9 gain blocked", gain_code, 4);
        send_ptr(8'h1C);
        check("R9 chsel blocked", mux_sel, 1);
        send_ptr(8'h08);
        check("R9 isense blocked", isense_sel, 0);
        send_ptr(8'h22); send_byte(8'h01); send_byte(8'h23);
        send_ptr(8'h01);
        check("R9 reset blocked", gain_code, 4);
        send_ptr(8'h05);
        send_ptr(8'h06); read_byte(v);
        check("R9 read in sleep", v, 8'h04);
        send_ptr(8'h07); send_byte(8'h01);
        check("R9 ldo wr in sleep", ldo_low_v, 1);
        check("R4 ldo stays on", ldo_en, 1);
        send_ptr(8'h04);
        check("R8 wake", analog_pd, 0);
        send_ptr(8'h22); read_byte(v);
        check("R9 ofs wr blocked", v, 8'h00);
        read_byte(v);
        check("R9 ofs wr blocked lo", v, 8'h00);
        check("R9 mux kept", mux_sel, 1);
    endtask

    task automatic t_softreset();
        logic [7:0] v;
        send_ptr(8'h1E);
        send_ptr(8'h08);
        send_ptr(8'h01);
        check("R10 mux", mux_sel, 0);     check("R10 gain", gain_code, 0);
        check("R10 ldov", ldo_low_v, 0);  check("R10 isense", isense_sel, 0);
        check("R10 ofs ch1", offset_word, 0);
        send_ptr(8'h2E); read_byte(v); read_byte(v);
        check("R10 ch8 ofs cleared", v, 8'h00);
        send_ptr(8'h07); read_byte(v);
        check("R10 ldo reg", v, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chsel();
        t_gain();
        t_offset();
        t_ids();
        t_isense();
        t_sleep();
        t_softreset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule